// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is the synchronous control core of a byte-wide parallel EEPROM. It samples asynchronous chip-enable, write-enable, output-enable and reset strobes (all active low) on a system clock through two-flop synchronizers. A write strobe is the overlap of chip-enable and write-enable. The address is taken when that overlap begins and the data byte when it ends. Bytes are gathered into a page buffer, and the page number is fixed by the first byte of a load. When no further byte arrives for a load window, a timed internal write cycle copies the buffered bytes into the memory array.

While the write cycle runs, any read returns status instead of array data. Bit 7 carries the inverse of bit 7 of the last loaded byte. Bit 6 alternates on every read and starts at 1. A separate open-drain busy output pulls low from the first accepted byte until the write cycle ends. Holding the reset strobe low blocks reads and writes, releases the data bus and the busy line, and abandons any load or write in progress. All timings are parameters counted in clock cycles, so a bench can shorten them.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After synchronous reset, `dout_en` and `rb_low` are 0 and `dout` is 0.
- R2: A single byte written while idle is stored in the array once its load window and write cycle have passed, and a later read of that address returns it.
- R3: The first byte of a load fixes the page (address bits above the low `PAGE_W` bits). Later bytes in the same load take only their low `PAGE_W` address bits as the offset in that page.
- R4: A load closes and the write cycle starts `LOAD_WIN` cycles after the last accepted byte. Each byte that arrives inside the window restarts it.
- R5: The write cycle lasts `WRITE_CYC` cycles. `rb_low` is 1 from the cycle after the first accepted byte until the write cycle ends, and 0 otherwise.
- R6: A read during the write cycle shows the complement of bit 7 of the last loaded byte on `dout[7]`. After the write finishes, the true stored byte is read.
- R7: During the write cycle, `dout[6]` is 1 on the first read and inverts on each following read.
- R8: A write strobe during the write cycle is ignored. It changes no array location, does not alter the page being written, and starts no new load after the cycle ends.
- R9: While the reset strobe is low, `dout_en` and `rb_low` are 0, write strobes are not accepted, and a running load or write is abandoned.
- R10: `dout_en` is 1 only while chip-enable and output-enable are low, write-enable is high and the reset strobe is high. Outside a write cycle, a read returns the array contents at `addr`.
- R11: The data byte is taken when the write strobe ends. A byte whose `din` changes while the strobe is active stores the value present at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| res_n | input | 1 | Reset/protect strobe, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or write-cycle status |
| dout_en | output | 1 | Data bus drive enable |
| rb_low | output | 1 | 1 pulls the open-drain ready/busy line low, 0 leaves it floating |

## Verification
The hardest state to reach from the ports is a write strobe, or a run of reads, landing inside the write cycle. The write cycle only begins after a silent load window, so the bench closes a page, waits past `LOAD_WIN`, and then polls status several times in a row to see the toggle sequence and the inverted bit 7. It then fires a stray strobe at a location whose old contents it knows. Abort behaviour is reached the same way: the reset strobe drops inside the write cycle, and while it is low a further strobe is issued that must not open a new load.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eepc_state_t;
endpackage

// File: rtl/eepc_sync.sv
// Two-flop synchronizer for a vector of asynchronous strobes.
module eepc_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= RST_VAL[i];
        q[i] <= RST_VAL[i];
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/eepc_pbuf.sv
// Page buffer: one byte plus a valid flag per page offset.
module eepc_pbuf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              busy,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) valid <= '0;
    else if (wr_en) valid[wr_off] <= 1'b1;
  end

  assign rd_data  = slot[rd_idx];
  assign rd_valid = valid[rd_idx];

  // Buffer contents frozen while the write cycle runs
  assert_buf_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr) |=> $stable(valid));
endmodule

// File: rtl/eepc_seq.sv
// Load-window timer, write-cycle timer, array walk and toggle bit.
module eepc_seq
  import eepc_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int LOAD_WIN  = 200,
  parameter int WRITE_CYC = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_ok,
  input  logic              byte_done,
  input  logic              rd_end,
  output eepc_state_t       st,
  output logic              walk_en,
  output logic [PAGE_W-1:0] walk_idx,
  output logic              clr,
  output logic              tog
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MAXC  = (LOAD_WIN > WRITE_CYC) ? LOAD_WIN : WRITE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic win_done, prog_done;

  assign win_done  = (cnt == CNT_W'(LOAD_WIN - 1));
  assign prog_done = (cnt == CNT_W'(WRITE_CYC - 1));
  assign walk_en   = (st == ST_PROG) && (cnt < CNT_W'(PAGE_BYTES));
  assign walk_idx  = cnt[PAGE_W-1:0];
  assign clr       = ((st != ST_IDLE) && !res_ok) || ((st == ST_PROG) && prog_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
      tog <= 1'b1;
    end else if (!res_ok) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (byte_done) begin
          st  <= ST_LOAD;
          cnt <= '0;
        end
        ST_LOAD: begin
          if (byte_done) cnt <= '0;
          else if (win_done) begin
            st  <= ST_PROG;
            cnt <= '0;
            tog <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_PROG: begin
          if (rd_end) tog <= ~tog;
          if (prog_done) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_load_win_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (cnt < CNT_W'(LOAD_WIN)));
  assert_prog_len_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG) |-> (cnt < CNT_W'(WRITE_CYC)));
  assert_tog_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && rd_end && res_ok && !prog_done) |=> (tog != $past(tog)));
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eepc_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 6,
  parameter int LOAD_WIN  = 200,
  parameter int WRITE_CYC = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              res_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rb_low
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [3:0] sync_q;
  logic ce_s, we_s, oe_s, res_s;
  logic wr_act, rd_act, wr_q, rd_q;
  logic wr_start, byte_done, rd_end, accept;
  logic [ADDR_W-1:0] a_lat;
  logic [PG_W-1:0]   page_base;
  logic              last7;
  eepc_state_t       st;
  logic              walk_en, clr, tog;
  logic [PAGE_W-1:0] walk_idx;
  logic [DATA_W-1:0] buf_rd, mem_q;
  logic              buf_valid, mem_we;
  logic [DATA_W-1:0] arr [DEPTH];

  eepc_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
    .clk(clk), .rst(rst), .d({res_n, oe_n, we_n, ce_n}), .q(sync_q)
  );
  assign {res_s, oe_s, we_s, ce_s} = sync_q;

  assign wr_act    = res_s && !ce_s && !we_s;
  assign rd_act    = res_s && !ce_s && !oe_s && we_s;
  assign wr_start  = wr_act && !wr_q;
  assign byte_done = wr_q && !wr_act && res_s;
  assign rd_end    = rd_q && !rd_act;
  assign accept    = byte_done && (st != ST_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  // Address at strobe start; page fixed by the first byte of a load
  always_ff @(posedge clk) begin
    if (rst) begin
      a_lat     <= '0;
      page_base <= '0;
      last7     <= 1'b0;
    end else begin
      if (wr_start && st != ST_PROG) a_lat <= addr;
      if (wr_start && st == ST_IDLE) page_base <= addr[ADDR_W-1:PAGE_W];
      if (accept) last7 <= din[DATA_W-1];
    end
  end

  eepc_seq #(.PAGE_W(PAGE_W), .LOAD_WIN(LOAD_WIN), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk(clk), .rst(rst), .res_ok(res_s), .byte_done(accept), .rd_end(rd_end),
    .st(st), .walk_en(walk_en), .walk_idx(walk_idx), .clr(clr), .tog(tog)
  );

  eepc_pbuf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_pbuf (
    .clk(clk), .rst(rst), .wr_en(accept), .wr_off(a_lat[PAGE_W-1:0]), .wr_data(din),
    .clr(clr), .busy(st == ST_PROG), .rd_idx(walk_idx),
    .rd_data(buf_rd), .rd_valid(buf_valid)
  );

  assign mem_we = walk_en && buf_valid && res_s;

  // Array: single write port, registered read (block RAM friendly)
  always_ff @(posedge clk) begin
    if (mem_we) arr[{page_base, walk_idx}] <= buf_rd;
    mem_q <= arr[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
      rb_low  <= 1'b0;
    end else begin
      dout_en <= rd_act;
      rb_low  <= res_s && (st != ST_IDLE);
      if (!rd_act)           dout <= '0;
      else if (st == ST_PROG) dout <= {~last7, tog, {(DATA_W-2){1'b0}}};
      else                   dout <= mem_q;
    end
  end

  assert_float_res_R9: assert property (@(posedge clk) disable iff (rst)
    !res_s |=> (!dout_en && !rb_low));
  assert_rb_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && res_s) |=> rb_low);
  assert_mem_we_prog_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (st == ST_PROG));
endmodule

// File: tb/eeprom_page_ctrl_tb.sv
module eeprom_page_ctrl_tb;
  localparam int AW = 10;
  localparam int LW = 200;
  localparam int WC = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, res_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, rb_low;

  int checks = 0;
  int fails = 0;
  int res_low_cnt = 0;
  logic [7:0] ref_mem [int];

  always #4 clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(AW), .DATA_W(8), .PAGE_W(6), .LOAD_WIN(LW), .WRITE_CYC(WC)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .res_n(res_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .rb_low(rb_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Per-clock reference: reset strobe held low means bus and busy released
  always @(posedge clk) res_low_cnt <= res_n ? 0 : res_low_cnt + 1;
  always @(negedge clk) if (!rst && res_low_cnt > 3) begin
    chk("R9 float", {30'd0, dout_en, rb_low}, 32'd0);
  end

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // CE-controlled byte: WE low first, data changes mid-strobe, CE released first
  task automatic wr_byte_ce(input logic [AW-1:0] a, input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk); addr = a; din = d0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    din = d1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (8) @(negedge clk);
    v = dout; en = dout_en;
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && rb_low; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic en;
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dout_en", dout_en, 0);
    chk("R1 rb_low", rb_low, 0);
    chk("R1 dout", dout, 0);

    // Preload two locations, each as its own page load
    ref_mem[324] = 8'h5A;
    wr_byte(10'd324, 8'h5A);
    chk("R5 busy after strobe", rb_low, 1);
    wait_idle();
    chk("R5 released", rb_low, 0);
    ref_mem[10] = 8'h11;
    wr_byte(10'd10, 8'h11);
    wait_idle();
    rd(10'd324, v, en);
    chk("R2 readback 324", v, 8'h5A);
    chk("R10 dout_en on read", en, 1);
    rd(10'd10, v, en);
    chk("R2 readback 10", v, 8'h11);

    // Multi-byte page: page 2 from the first byte, later bytes keep only their offset
    wr_byte(10'd131, 8'h81);
    wr_byte(10'd324, 8'h42);        // lands at page 2 offset 4 = 132
    wr_byte(10'd191, 8'h37);
    ref_mem[131] = 8'h81; ref_mem[132] = 8'h42; ref_mem[191] = 8'h37;
    repeat (LW + 20) @(negedge clk);
    rd(10'd0, v, en);
    chk("R6 poll bit7", v[7], 1);
    chk("R7 toggle first", v[6], 1);
    rd(10'd0, v, en);
    chk("R7 toggle second", v[6], 0);
    chk("R6 poll bit7 again", v[7], 1);
    rd(10'd0, v, en);
    chk("R7 toggle third", v[6], 1);
    wr_byte(10'd10, 8'hEE);         // stray strobe during write cycle
    chk("R8 still busy", rb_low, 1);
    wait_idle();
    repeat (LW + 50) @(negedge clk);
    chk("R8 no new load", rb_low, 0);
    rd(10'd131, v, en); chk("R3 first byte", v, ref_mem[131]);
    rd(10'd132, v, en); chk("R3 offset only", v, ref_mem[132]);
    rd(10'd191, v, en); chk("R6 true value after write", v, ref_mem[191]);
    rd(10'd324, v, en); chk("R3 other page untouched", v, ref_mem[324]);
    rd(10'd10, v, en);  chk("R8 stray ignored", v, ref_mem[10]);

    // R4/R5 busy length for one byte
    wr_byte(10'd20, 8'h99);
    ref_mem[20] = 8'h99;
    k = 0;
    while (rb_low && k < 5000) begin @(negedge clk); k++; end
    chk("R4 R5 busy length in range", (k >= LW + WC - 10 && k <= LW + WC + 5), 1);
    rd(10'd20, v, en); chk("R2 single byte", v, 8'h99);

    // R11 data taken at strobe release, CE-controlled
    wr_byte_ce(10'd30, 8'h00, 8'hC3);
    wait_idle();
    rd(10'd30, v, en); chk("R11 data at release", v, 8'hC3);

    // R10 no drive without chip enable
    @(negedge clk); addr = 10'd30; oe_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 oe without ce", dout_en, 0);
    oe_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 abort: reset strobe drops inside write cycle
    wr_byte(10'd40, 8'h66);
    repeat (LW + 10) @(negedge clk);
    res_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 busy released", rb_low, 0);
    rd(10'd30, v, en);
    chk("R9 no read drive", en, 0);
    wr_byte(10'd50, 8'h77);         // not accepted while reset strobe low
    res_n = 1'b1;
    repeat (LW + 20) @(negedge clk);
    chk("R9 no load after reset strobe", rb_low, 0);
    rd(10'd30, v, en);
    chk("R9 R10 array read after release", v, 8'hC3);
    chk("R9 drive after release", en, 1);

    summary();
  end
endmodule